// File: doc/BRIEF.md
# Thermal Alarm Unit with Swapped-Level Hysteresis

The block watches a sampled die temperature and tracks four alarms: downclock, shutdown, fan boost and critical. Each alarm has its own threshold and hysteresis value and a two-state record (LOWER or HIGHER). Each alarm has one active compare level. It sits at the threshold while the alarm is low. After an upward crossing it moves down to threshold minus hysteresis, so a reading that hovers near the threshold does not toggle the alarm.

When the reading crosses an alarm's active compare level, the alarm takes its next level from the swap rule. Its state is then corrected against the live reading. If the state changed, a one-cycle rising or falling event is emitted. Every crossing also sets a pending bit. The interrupt line is asserted while any pending bit has its enable bit set. Software sets the thresholds, hysteresis values and enables through a simple write port, and reads the registers back through a combinational read port.

Top module: `thm_alarm_unit`

## Requirements
- R1: Reset state. After synchronous active-low reset:
  - every alarm is LOWER and no event is active;
  - the pending and enable registers read 0;
  - every threshold reads 511 and every hysteresis reads 0;
  - the interrupt is low.
- R2: Register map, word addresses on a 4-bit address:
  - 0 = interrupt enable (10 bits);
  - 1 = pending status;
  - 2 = current temperature (read-only);
  - 4+k = threshold of alarm k (9 bits);
  - 8+k = hysteresis of alarm k (8 bits).
  - Alarm index k: 0 downclock, 1 shutdown, 2 fan boost, 3 critical.
  - Output vectors use bit k for alarm k.
- R3: A crossing is a change, between consecutive cycles, in whether the temperature is strictly above the active level. On a crossing while the level equals the threshold, the level becomes threshold minus hysteresis and the state becomes HIGHER. A LOWER to HIGHER change pulses the rise output for one cycle, in the cycle the state output changes.
- R4: On a crossing while the level differs from the threshold, the level returns to the threshold and the state becomes LOWER. A HIGHER to LOWER change pulses the fall output for one cycle. Rise and fall are never active together for one alarm.
- R5: While HIGHER, temperatures between threshold minus hysteresis (exclusive) and the threshold cause no event and no state change.
- R6: After each crossing the state is corrected against the live temperature:
  - a LOWER result with temperature above the threshold becomes HIGHER;
  - a HIGHER result with temperature below threshold minus hysteresis becomes LOWER.
  - The event is taken from the corrected state.
- R7: Every crossing of alarm k sets pending bit k+1: bit 1 downclock, bit 2 shutdown, bit 3 fan boost, bit 4 critical. The interrupt is the OR of pending AND enable over all 10 bits.
- R8: Writing ones to the status address clears the matching pending bits. A crossing in the same cycle as a clear of its bit leaves the bit set.
- R9: A write to a threshold sets that alarm's level to the new threshold. It sets the state to HIGHER exactly when the temperature is above the new threshold. It emits no event and sets no pending bit.
- R10: Threshold minus hysteresis saturates at 0.
- R11: Address 2 returns the live temperature input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_i | input | 9 | Sampled temperature, unsigned |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write word address |
| wr_data_i | input | 10 | Write data |
| rd_addr_i | input | 4 | Read word address |
| rd_data_o | output | 10 | Read data, combinational |
| alarm_hi_o | output | 4 | Per-alarm state, 1 = HIGHER |
| evt_rise_o | output | 4 | Per-alarm rising event pulse |
| evt_fall_o | output | 4 | Per-alarm falling event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The state correction (R6) is the hardest situation to reach. A crossing normally lands the reading just past the active level, so the correction has nothing to change. The stimulus first uses a threshold rewrite to leave an alarm HIGHER with its level still at the threshold. It then drops the reading far below the hysteresis band in one step, which forces a HIGHER to LOWER correction. It then jumps the reading far above the threshold, which forces a LOWER to HIGHER correction. The same-cycle clear and crossing of R8 is reached by driving a status write on the same edge as a temperature step across the level.

// File: rtl/thm_alarm_pkg.sv
// Package: shared constants for the thermal alarm unit.
// Assumes the four alarm indices below are fixed; pending bit = index + 1.
package thm_alarm_pkg;
    localparam int NUM_ALARM    = 4;
    localparam int STAT_W       = 10;
    localparam int ADR_ENABLE   = 0;
    localparam int ADR_STATUS   = 1;
    localparam int ADR_TEMP     = 2;
    localparam int ADR_THR_BASE = 4;
    localparam int ADR_HYS_BASE = 8;

    typedef enum logic [1:0] {
        ALM_DOWNCLK = 2'd0,
        ALM_SHUTDN  = 2'd1,
        ALM_FANBST  = 2'd2,
        ALM_CRIT    = 2'd3
    } alarm_idx_e;
endpackage

// File: rtl/thm_alarm_slice.sv
// Module: one alarm channel. Holds the active compare level, the side of the
// level the reading was on, and the LOWER/HIGHER state. Detects crossings,
// swaps the level, corrects the state and registers rise/fall pulses.
// Assumes HYST_W <= TEMP_W and that a reload has priority over a crossing.
module thm_alarm_slice #(
    parameter int TEMP_W = 9,
    parameter int HYST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] thr_i,
    input  logic [HYST_W-1:0] hyst_i,
    input  logic              reload_i,
    input  logic [TEMP_W-1:0] reload_val_i,
    output logic              fire_o,
    output logic              high_o,
    output logic              rise_o,
    output logic              fall_o
);
    logic [TEMP_W-1:0] lvl_q, lvl_n, low_lvl, hyst_ext;
    logic              side_q, high_q, rise_q, fall_q;
    logic              above_now, high_n;

    // Lower band edge: threshold minus hysteresis, clamped at zero.
    always_comb begin
        hyst_ext = TEMP_W'(hyst_i);
        low_lvl  = (thr_i > hyst_ext) ? (thr_i - hyst_ext) : '0;
    end

    // Crossing detect, level swap, state correction and reload override.
    always_comb begin
        above_now = (temp_i > lvl_q);
        fire_o    = (above_now != side_q) && !reload_i;
        lvl_n     = lvl_q;
        high_n    = high_q;
        if (reload_i) begin
            lvl_n  = reload_val_i;
            high_n = (temp_i > reload_val_i);
        end else if (fire_o) begin
            if (lvl_q == thr_i) begin
                lvl_n  = low_lvl;
                high_n = 1'b1;
            end else begin
                lvl_n  = thr_i;
                high_n = 1'b0;
            end
            if (!high_n && (temp_i > thr_i))
                high_n = 1'b1;
            else if (high_n && (temp_i < low_lvl))
                high_n = 1'b0;
        end
    end

    // State registers and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '1;
            side_q <= 1'b0;
            high_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            lvl_q  <= lvl_n;
            side_q <= (temp_i > lvl_n);
            high_q <= high_n;
            rise_q <= fire_o && !high_q && high_n;
            fall_q <= fire_o && high_q && !high_n;
        end
    end

    assign high_o = high_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;
endmodule

// File: rtl/thm_alarm_regs.sv
// Module: register file of the alarm unit. Holds thresholds, hysteresis,
// interrupt enable and pending bits, decodes writes, drives reload strobes,
// muxes reads and forms the interrupt.
// Assumes DATA_W >= STAT_W and DATA_W >= TEMP_W.
module thm_alarm_regs
    import thm_alarm_pkg::*;
#(
    parameter int TEMP_W = 9,
    parameter int HYST_W = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TEMP_W-1:0]               temp_i,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    input  logic [ADDR_W-1:0]               rd_addr_i,
    input  logic [NUM_ALARM-1:0]            fire_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic [NUM_ALARM-1:0][TEMP_W-1:0] thr_o,
    output logic [NUM_ALARM-1:0][HYST_W-1:0] hyst_o,
    output logic [NUM_ALARM-1:0]            reload_o,
    output logic [STAT_W-1:0]               pend_o,
    output logic                            irq_o
);
    logic [NUM_ALARM-1:0][TEMP_W-1:0] thr_q;
    logic [NUM_ALARM-1:0][HYST_W-1:0] hyst_q;
    logic [STAT_W-1:0]                en_q, pend_q, pend_set, pend_clr;
    logic [NUM_ALARM-1:0]             hyst_wr;

    // Write strobes per alarm and pending set/clear vectors.
    always_comb begin
        pend_set = '0;
        for (int k = 0; k < NUM_ALARM; k++) begin
            reload_o[k]     = wr_en_i && (wr_addr_i == ADDR_W'(ADR_THR_BASE + k));
            hyst_wr[k]      = wr_en_i && (wr_addr_i == ADDR_W'(ADR_HYS_BASE + k));
            pend_set[k + 1] = fire_i[k];
        end
        pend_clr = (wr_en_i && wr_addr_i == ADDR_W'(ADR_STATUS)) ?
                   wr_data_i[STAT_W-1:0] : '0;
    end

    // Configuration and pending storage; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '1;
            hyst_q <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            for (int k = 0; k < NUM_ALARM; k++) begin
                if (reload_o[k]) thr_q[k]  <= wr_data_i[TEMP_W-1:0];
                if (hyst_wr[k])  hyst_q[k] <= wr_data_i[HYST_W-1:0];
            end
            if (wr_en_i && wr_addr_i == ADDR_W'(ADR_ENABLE))
                en_q <= wr_data_i[STAT_W-1:0];
            pend_q <= (pend_q & ~pend_clr) | pend_set;
        end
    end

    // Combinational read mux.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADR_ENABLE)) rd_data_o = DATA_W'(en_q);
        if (rd_addr_i == ADDR_W'(ADR_STATUS)) rd_data_o = DATA_W'(pend_q);
        if (rd_addr_i == ADDR_W'(ADR_TEMP))   rd_data_o = DATA_W'(temp_i);
        for (int k = 0; k < NUM_ALARM; k++) begin
            if (rd_addr_i == ADDR_W'(ADR_THR_BASE + k)) rd_data_o = DATA_W'(thr_q[k]);
            if (rd_addr_i == ADDR_W'(ADR_HYS_BASE + k)) rd_data_o = DATA_W'(hyst_q[k]);
        end
    end

    assign thr_o  = thr_q;
    assign hyst_o = hyst_q;
    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/thm_alarm_unit.sv
// Module: top of the thermal alarm unit. One register file plus one
// hysteresis slice per alarm, built with a generate loop.
// Assumes temp_i is already synchronous to clk.
module thm_alarm_unit
    import thm_alarm_pkg::*;
#(
    parameter int TEMP_W = 9,
    parameter int HYST_W = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TEMP_W-1:0]    temp_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_ALARM-1:0] alarm_hi_o,
    output logic [NUM_ALARM-1:0] evt_rise_o,
    output logic [NUM_ALARM-1:0] evt_fall_o,
    output logic                 irq_o
);
    logic [NUM_ALARM-1:0][TEMP_W-1:0] thr_w;
    logic [NUM_ALARM-1:0][HYST_W-1:0] hyst_w;
    logic [NUM_ALARM-1:0]             reload_w, fire_w;
    logic [STAT_W-1:0]                pend_vec;

    thm_alarm_regs #(
        .TEMP_W(TEMP_W), .HYST_W(HYST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .fire_i(fire_w), .rd_data_o(rd_data_o),
        .thr_o(thr_w), .hyst_o(hyst_w), .reload_o(reload_w),
        .pend_o(pend_vec), .irq_o(irq_o)
    );

    for (genvar k = 0; k < NUM_ALARM; k++) begin : g_alarm
        thm_alarm_slice #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_slice (
            .clk(clk), .rst_n(rst_n), .temp_i(temp_i),
            .thr_i(thr_w[k]), .hyst_i(hyst_w[k]),
            .reload_i(reload_w[k]), .reload_val_i(wr_data_i[TEMP_W-1:0]),
            .fire_o(fire_w[k]), .high_o(alarm_hi_o[k]),
            .rise_o(evt_rise_o[k]), .fall_o(evt_fall_o[k])
        );
    end
endmodule

// File: rtl/thm_alarm_unit_chk.sv
// Checker: temporal properties of the alarm unit, bound to the top.
module thm_alarm_unit_chk #(
    parameter int NA = 4,
    parameter int SW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NA-1:0] state,
    input logic [NA-1:0] rise,
    input logic [NA-1:0] fall,
    input logic [SW-1:0] pend,
    input logic          irq
);
    logic [SW-1:0] evt_mask;
    always_comb evt_mask = SW'({rise | fall, 1'b0});

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (state == '0 && rise == '0 && fall == '0 && pend == '0 && !irq));

    a_r3_rise_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & ~state) == '0);

    a_r3_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |-> ((rise & $past(state)) == '0));

    a_r4_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |-> ((fall & ~$past(state)) == '0 && (fall & state) == '0));

    a_r4_no_dual_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & fall) == '0);

    a_r7_event_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mask & ~pend) == '0);
endmodule

bind thm_alarm_unit thm_alarm_unit_chk #(
    .NA(thm_alarm_pkg::NUM_ALARM), .SW(thm_alarm_pkg::STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(alarm_hi_o), .rise(evt_rise_o),
    .fall(evt_fall_o), .pend(pend_vec), .irq(irq_o)
);

// File: tb/tb_thm_alarm_unit.sv
`timescale 1ns/1ps
module tb_thm_alarm_unit;
    localparam int TW = 9, HW = 8, AW = 4, DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] temp_i = 9'd50;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic [3:0]    alarm_hi_o, evt_rise_o, evt_fall_o;
    logic          irq_o;

    always #2.5 clk = ~clk;

    thm_alarm_unit dut (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .alarm_hi_o(alarm_hi_o), .evt_rise_o(evt_rise_o),
        .evt_fall_o(evt_fall_o), .irq_o(irq_o)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0] hi, rise, fall;
        logic       irq;
        string      tag;
    } item_t;
    item_t exp_q[$];
    item_t mon_it;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per edge after the driver queued it.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            mon_it = exp_q.pop_front();
            chk({mon_it.tag, " state"}, 32'(alarm_hi_o), 32'(mon_it.hi));
            chk({mon_it.tag, " rise"},  32'(evt_rise_o), 32'(mon_it.rise));
            chk({mon_it.tag, " fall"},  32'(evt_fall_o), 32'(mon_it.fall));
            chk({mon_it.tag, " irq"},   32'(irq_o),      32'(mon_it.irq));
        end
    end

    // Driver: apply a temperature and queue the outcome of the next edge.
    task automatic step(input logic [TW-1:0] t, input logic [3:0] hi,
                        input logic [3:0] ri, input logic [3:0] fa,
                        input logic iq, input string tag);
        item_t it;
        @(negedge clk);
        temp_i = t;
        it.hi = hi; it.rise = ri; it.fall = fa; it.irq = iq; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        rd_addr_i = a;
        #1;
        chk(tag, 32'(rd_data_o), 32'(e));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values
        chk("R1 state", 32'(alarm_hi_o), 0);
        chk("R1 events", 32'({evt_rise_o, evt_fall_o}), 0);
        chk("R1 irq", 32'(irq_o), 0);
        rd_chk(4'd0, 10'h000, "R1 enable");
        rd_chk(4'd1, 10'h000, "R1 status");
        rd_chk(4'd4, 10'h1FF, "R1 thr0");
        rd_chk(4'd8, 10'h000, "R1 hyst0");
        rd_chk(4'd2, 10'd50, "R11 temp");
        step(9'd50, 4'b0000, 4'b0000, 4'b0000, 1'b0, "R1 idle");

        // R2 program downclock alarm: threshold 100, hysteresis 10
        wr(4'd8, 10'd10);
        wr(4'd4, 10'd100);
        rd_chk(4'd4, 10'd100, "R2 thr0");
        rd_chk(4'd8, 10'd10, "R2 hyst0");

        // R3 upward crossing
        step(9'd101, 4'b0001, 4'b0001, 4'b0000, 1'b0, "R3 rise");
        step(9'd101, 4'b0001, 4'b0000, 4'b0000, 1'b0, "R3 pulse ends");
        // R5 inside band
        step(9'd95, 4'b0001, 4'b0000, 4'b0000, 1'b0, "R5 band 95");
        step(9'd91, 4'b0001, 4'b0000, 4'b0000, 1'b0, "R5 band 91");
        // R4 fall at threshold minus hysteresis
        step(9'd90, 4'b0000, 4'b0000, 4'b0001, 1'b0, "R4 fall");

        // R7 pending bit 1 for downclock, gated by enable
        rd_chk(4'd1, 10'h002, "R7 status downclock");
        chk("R7 irq masked", 32'(irq_o), 0);
        wr(4'd0, 10'h002);
        chk("R7 irq enabled", 32'(irq_o), 1);
        // R8 write one to clear
        wr(4'd1, 10'h002);
        rd_chk(4'd1, 10'h000, "R8 cleared");
        chk("R8 irq low", 32'(irq_o), 0);

        // R9 threshold rewrite below reading: HIGHER, no event, no pending
        wr(4'd4, 10'd80);
        chk("R9 state", 32'(alarm_hi_o), 32'h1);
        chk("R9 no event", 32'({evt_rise_o, evt_fall_o}), 0);
        rd_chk(4'd1, 10'h000, "R9 no pending");

        // R6 correction in both directions
        step(9'd60, 4'b0000, 4'b0000, 4'b0001, 1'b1, "R6 drop below band");
        step(9'd200, 4'b0001, 4'b0001, 4'b0000, 1'b1, "R6 jump above thr");

        // R8 set wins over same-cycle clear
        wr(4'd1, 10'h002);
        rd_chk(4'd1, 10'h000, "R8 clear before race");
        @(negedge clk);
        temp_i = 9'd70;
        wr_en_i = 1'b1; wr_addr_i = 4'd1; wr_data_i = 10'h002;
        @(negedge clk);
        wr_en_i = 1'b0;
        rd_chk(4'd1, 10'h002, "R8 set wins");
        chk("R8 state kept", 32'(alarm_hi_o), 32'h1);
        wr(4'd1, 10'h002);
        rd_chk(4'd1, 10'h000, "R8 cleared after race");

        // R10 saturation on fan boost alarm (index 2, pending bit 3)
        wr(4'd10, 10'd20);
        wr(4'd6, 10'd5);
        chk("R10 reload high", 32'(alarm_hi_o), 32'h5);
        step(9'd3, 4'b0101, 4'b0000, 4'b0000, 1'b0, "R10 above zero floor");
        step(9'd0, 4'b0001, 4'b0000, 4'b0100, 1'b0, "R10 fall at zero");
        rd_chk(4'd1, 10'h008, "R7 status fan boost");
        chk("R7 irq other bit masked", 32'(irq_o), 0);
        wr(4'd0, 10'h3FF);
        chk("R7 irq all enabled", 32'(irq_o), 1);
        rd_chk(4'd2, 10'd0, "R11 temp zero");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule